// File: doc/BRIEF.md
# Flash Write-Cycle Qualifier

This block sits between the raw control pins of a flash-style memory port and its command logic. It watches the active-low chip-select, write-strobe and output-enable lines. It decides which bus activity is a genuine write cycle. When a write qualifies, it hands the command logic a single-cycle accept pulse along with the address and data captured with it. It also reports when the pins describe a read.

Each strobe first passes through a per-pin deglitcher. A level change counts only after it has held for a parameterised number of clock cycles. The cleaned strobes then go through the pin-combination rules. A write needs select and write-strobe low while output-enable is high. Any other mix is inhibited, and all three low is treated as a read.

A supply guard holds the command logic in reset, and drops every write, in three cases: while a low-voltage flag is raised, while the supply is not reported good, and for a fixed settle time after the supply becomes healthy. A write whose pin pattern began while the guard was closed is refused, even if its strobe rises after the guard opens.

Top module: `flash_wr_qualifier`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `wr_accept` is 0, `rd_cycle` is 0 and `cmd_rst` is 1.
- R2: Consider a write where `ce_n`=0 and `oe_n`=1, with `we_n` pulled low and released while the supply guard is open. It produces exactly one `wr_accept` pulse, one clock wide. `wr_addr`/`wr_data` carry the `addr`/`data` values held across that write.
- R3: No write is accepted if `oe_n` is low, or `ce_n` is high, when the deglitched write strobe rises. This includes `oe_n` falling partway through the write-strobe low period.
- R4: With `ce_n`, `we_n` and `oe_n` all low, `rd_cycle` reads 1, and releasing `we_n` afterwards yields no `wr_accept`.
- R5: A `we_n` low pulse shorter than `FILT_CYC` clock cycles is discarded and never yields `wr_accept`. A pulse of `FILT_CYC` cycles or more is honoured.
- R6: The clock edge after `vlow` is sampled high, `cmd_rst` is 1, and it remains 1 while `vlow` stays high. No `wr_accept` is issued while `cmd_rst` is 1.
- R7: `cmd_rst` clears on the `PUP_CYC`-th consecutive clock edge at which `pgood`=1 and `vlow`=0, and not earlier. A complete write pattern seen before then is refused.
- R8: A write whose select/write-strobe pattern began while `cmd_rst` was 1 is refused even when `we_n` rises after `cmd_rst` has cleared.
- R9: `rd_cycle` is 1 exactly when the deglitched `ce_n` and `oe_n` are both low. A change on a pin reaches `rd_cycle` `FILT_CYC`+2 edges after it is first sampled.
- R10: Consider a write-strobe rise that would raise `wr_accept` at the same edge where `vlow` is first sampled high. The lockout wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Address bus |
| data | input | DW | Write data bus |
| vlow | input | 1 | Supply below lockout threshold |
| pgood | input | 1 | Supply reported good |
| wr_accept | output | 1 | One-cycle pulse for a qualified write |
| wr_addr | output | AW | Address captured with the write |
| wr_data | output | DW | Data captured with the write |
| rd_cycle | output | 1 | Pins describe a read |
| cmd_rst | output | 1 | Reset to the command logic |

## Verification
Two functions can act at the same clock edge: the deglitched write-strobe rise that completes a write, and the low-voltage lockout closing. The bench raises `vlow` in the exact cycle where the accept would be registered, and expects the write to be dropped with `cmd_rst` set. It then repeats the test one cycle later and expects the write to go through with `vlow` following it. A scoreboard queue holds the expected writes, so any accept that appears in the wrong case shows up as a spurious or missing item.

// File: rtl/flash_wq_pkg.sv
package flash_wq_pkg;
  typedef enum int unsigned {
    PIN_CE = 0,
    PIN_WE = 1,
    PIN_OE = 2
  } pin_idx_e;

  localparam int unsigned NUM_PINS = 3;

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } strobe_t;
endpackage

// File: rtl/wq_deglitch.sv
module wq_deglitch #(
  parameter int unsigned FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int unsigned CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic          smp_q;
  logic [CW-1:0] run_q;
  logic          clean_q;

  // input sample register, then a run counter on disagreement
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_q   <= 1'b1;
      run_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      smp_q <= raw;
      if (smp_q == clean_q) begin
        run_q <= '0;
      end else if (run_q == LAST) begin
        clean_q <= smp_q;
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign clean = clean_q;
endmodule

// File: rtl/wq_supply_lock.sv
module wq_supply_lock #(
  parameter int unsigned PUP_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic vlow,
  input  logic pgood,
  output logic ready_q,
  output logic ready_d
);
  localparam int unsigned CW = (PUP_CYC < 2) ? 1 : $clog2(PUP_CYC);
  localparam logic [CW-1:0] LAST = CW'(PUP_CYC - 1);

  logic [CW-1:0] settle_q;
  logic          supply_bad;
  logic          rdy_q;

  assign supply_bad = vlow | ~pgood;

  always_comb begin
    if (supply_bad)   ready_d = 1'b0;
    else if (rdy_q)   ready_d = 1'b1;
    else              ready_d = (settle_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settle_q <= '0;
      rdy_q    <= 1'b0;
    end else begin
      rdy_q <= ready_d;
      if (supply_bad)
        settle_q <= '0;
      else if (!rdy_q && settle_q != LAST)
        settle_q <= settle_q + 1'b1;
    end
  end

  assign ready_q = rdy_q;
endmodule

// File: rtl/wq_cycle_judge.sv
module wq_cycle_judge
  import flash_wq_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       pins,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          ready_d,
  output logic          wr_accept,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_cycle
);
  logic we_prev_q;
  logic armed_q;
  logic we_rise;
  logic wr_pattern;
  logic take;

  assign we_rise    = pins.we & ~we_prev_q;
  assign wr_pattern = ~pins.ce & ~pins.we & pins.oe;
  assign take       = armed_q & we_rise & pins.oe & ready_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_prev_q <= 1'b1;
      armed_q   <= 1'b0;
      wr_accept <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_cycle  <= 1'b0;
    end else begin
      we_prev_q <= pins.we;
      wr_accept <= take;
      rd_cycle  <= ~pins.ce & ~pins.oe;
      if (take) begin
        wr_addr <= addr;
        wr_data <= data;
      end
      // arming only while the guard is open; a pattern begun locked never arms
      if (!ready_d)
        armed_q <= 1'b0;
      else if (pins.ce || !pins.oe || we_rise)
        armed_q <= 1'b0;
      else if (wr_pattern && we_prev_q)
        armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/flash_wr_qualifier.sv
module flash_wr_qualifier
  import flash_wq_pkg::*;
#(
  parameter int unsigned AW       = 20,
  parameter int unsigned DW       = 16,
  parameter int unsigned FILT_CYC = 2,
  parameter int unsigned PUP_CYC  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          vlow,
  input  logic          pgood,
  output logic          wr_accept,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_cycle,
  output logic          cmd_rst
);
  logic [NUM_PINS-1:0] raw_pins;
  logic [NUM_PINS-1:0] clean_pins;
  strobe_t             pins;
  logic                ready_q;
  logic                ready_d;

  assign raw_pins[PIN_CE] = ce_n;
  assign raw_pins[PIN_WE] = we_n;
  assign raw_pins[PIN_OE] = oe_n;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    wq_deglitch #(.FILT_CYC(FILT_CYC)) u_flt (
      .clk   (clk),
      .rst   (rst),
      .raw   (raw_pins[i]),
      .clean (clean_pins[i])
    );
  end

  assign pins.ce = clean_pins[PIN_CE];
  assign pins.we = clean_pins[PIN_WE];
  assign pins.oe = clean_pins[PIN_OE];

  wq_supply_lock #(.PUP_CYC(PUP_CYC)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .vlow    (vlow),
    .pgood   (pgood),
    .ready_q (ready_q),
    .ready_d (ready_d)
  );

  wq_cycle_judge #(.AW(AW), .DW(DW)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .pins      (pins),
    .addr      (addr),
    .data      (data),
    .ready_d   (ready_d),
    .wr_accept (wr_accept),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_cycle  (rd_cycle)
  );

  assign cmd_rst = ~ready_q;
endmodule

// File: rtl/flash_wr_qualifier_chk.sv
module flash_wr_qualifier_chk (
  input logic clk,
  input logic rst,
  input logic vlow,
  input logic pgood,
  input logic wr_accept,
  input logic rd_cycle,
  input logic cmd_rst
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !wr_accept);

  p_read_excl_r4: assert property (@(posedge clk) disable iff (rst)
    rd_cycle |-> !wr_accept);

  p_vlow_r6: assert property (@(posedge clk) disable iff (rst)
    vlow |=> cmd_rst);

  p_locked_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_rst |-> !wr_accept);

  p_pgood_r7: assert property (@(posedge clk) disable iff (rst)
    !pgood |=> cmd_rst);

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_rst) |-> $past(pgood && !vlow));
endmodule

bind flash_wr_qualifier flash_wr_qualifier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .vlow      (vlow),
  .pgood     (pgood),
  .wr_accept (wr_accept),
  .rd_cycle  (rd_cycle),
  .cmd_rst   (cmd_rst)
);

// File: tb/flash_wr_qualifier_tb.sv
module flash_wr_qualifier_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int FILT = 3;
  localparam int PUP = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic vlow = 1'b0, pgood = 1'b0;
  logic wr_accept, rd_cycle, cmd_rst;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int n_chk = 0, n_fail = 0, spurious = 0;
  logic [AW+DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  flash_wr_qualifier #(.AW(AW), .DW(DW), .FILT_CYC(FILT), .PUP_CYC(PUP)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .vlow(vlow), .pgood(pgood),
    .wr_accept(wr_accept), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_cycle(rd_cycle), .cmd_rst(cmd_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accept pulse
  always @(negedge clk) begin
    if (!rst && wr_accept) begin
      if (exp_q.size() == 0) spurious++;
      else chk("R2 captured addr/data", {wr_addr, wr_data}, exp_q.pop_front());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input [AW-1:0] a, input [DW-1:0] d, input int low, input bit ok);
    @(negedge clk); addr = a; data = d; ce_n = 0; oe_n = 1;
    cyc(2); we_n = 0; cyc(low); we_n = 1;
    if (ok) exp_q.push_back({a, d});
    cyc(FILT + 4); ce_n = 1; cyc(FILT + 4);
  endtask

  task automatic none_since(input string req, input int snap);
    chk(req, spurious, snap);
  endtask

  initial begin
    int snap;
    cyc(3);
    chk("R1 wr_accept in reset", wr_accept, 0);
    chk("R1 rd_cycle in reset", rd_cycle, 0);
    chk("R1 cmd_rst in reset", cmd_rst, 1);
    @(negedge clk); rst = 0; pgood = 1;
    @(negedge clk);
    chk("R1 cmd_rst after reset", cmd_rst, 1);
    // R7: a complete write during the settle window is refused
    snap = spurious;
    wr(8'h11, 8'h22, 5, 0);
    none_since("R7 write during power-up", snap);
    // R7: release exactly on the PUP-th good edge
    pgood = 0; cyc(2); pgood = 1;
    cyc(PUP - 1);
    chk("R7 cmd_rst before settle", cmd_rst, 1);
    cyc(1);
    chk("R7 cmd_rst after settle", cmd_rst, 0);
    // R2: normal writes
    wr(8'hA5, 8'h3C, 5, 1);
    wr(8'h5A, 8'hC3, 8, 1);
    wr(8'h00, 8'hFF, FILT, 1);          // R5 minimum accepted pulse
    // R5: glitch shorter than the filter
    snap = spurious;
    wr(8'h77, 8'h88, FILT - 1, 0);
    none_since("R5 short we_n pulse", snap);
    // R3: oe low during write, ce high with we pulse, oe falling mid-write
    snap = spurious;
    @(negedge clk); ce_n = 0; oe_n = 0; cyc(2); we_n = 0; cyc(6); we_n = 1; cyc(FILT + 4);
    ce_n = 1; oe_n = 1; cyc(FILT + 4);
    @(negedge clk); ce_n = 1; we_n = 0; cyc(6); we_n = 1; cyc(FILT + 6);
    @(negedge clk); ce_n = 0; cyc(2); we_n = 0; cyc(6); oe_n = 0; cyc(FILT + 3); we_n = 1;
    cyc(FILT + 4); ce_n = 1; oe_n = 1; cyc(FILT + 4);
    none_since("R3 inhibited writes", snap);
    // R4/R9: all three low is a read
    snap = spurious;
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; cyc(FILT + 4);
    chk("R4 rd_cycle all low", rd_cycle, 1);
    we_n = 1; cyc(FILT + 4);
    none_since("R4 no write on all-low", snap);
    chk("R9 rd_cycle ce/oe low", rd_cycle, 1);
    ce_n = 1; cyc(FILT + 1);
    chk("R9 rd_cycle before latency", rd_cycle, 1);
    cyc(1);
    chk("R9 rd_cycle after ce_n high", rd_cycle, 0);
    oe_n = 1; cyc(FILT + 4);
    // R6/R8: pattern started under low voltage, finished after release
    snap = spurious;
    @(negedge clk); vlow = 1; addr = 8'h42; data = 8'h24; ce_n = 0; oe_n = 1;
    @(negedge clk);
    chk("R6 cmd_rst on vlow", cmd_rst, 1);
    we_n = 0; cyc(FILT + 4); vlow = 0; cyc(PUP + 4);
    chk("R6 cmd_rst released", cmd_rst, 0);
    we_n = 1; cyc(FILT + 4); ce_n = 1; cyc(FILT + 4);
    none_since("R8 write armed while locked", snap);
    // R10: vlow arrives at the accept edge
    snap = spurious;
    @(negedge clk); addr = 8'h66; data = 8'h99; ce_n = 0; oe_n = 1; cyc(2);
    we_n = 0; cyc(6); we_n = 1; cyc(FILT + 1); vlow = 1; cyc(2);
    chk("R10 cmd_rst after collision", cmd_rst, 1);
    cyc(FILT + 3); ce_n = 1; vlow = 0; cyc(PUP + 4);
    none_since("R10 lockout wins collision", snap);
    // one cycle later the write survives
    @(negedge clk); addr = 8'h67; data = 8'h98; ce_n = 0; oe_n = 1; cyc(2);
    we_n = 0; cyc(6); we_n = 1; exp_q.push_back({8'h67, 8'h98}); cyc(FILT + 2); vlow = 1;
    cyc(FILT + 3); ce_n = 1; vlow = 0; cyc(PUP + 4);
    wr(8'hC8, 8'h8C, 4, 1);
    cyc(4);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    chk("R2 no spurious accepts", spurious, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule